// File: doc/BRIEF.md
# MAC Address EEPROM Programming Sequencer

This block stores a 48-bit station address in a serial EEPROM so that the address survives power cycles. A one-cycle start pulse captures the address, presents it at once on a load output for the live address filter, and then (if programming is enabled) drives a sequence of commands into the command port of a separate serial EEPROM master. The master carries out the bit-level protocol and reports completion with a one-cycle acknowledge.

The address is split into three 16-bit words. Each word goes out as a write-enable command, a write and a read-back of the same location. The read-back is compared with the word that was written. A mismatch, or a master that never acknowledges, causes the whole attempt to be repeated, up to a fixed number of attempts. A word that still fails is flagged and the sequencer moves on to the next word. When the last word is finished, a done pulse is issued together with a per-word failure mask.

The master command port carries a request level, a 2-bit operation code, a 6-bit word address and 16 bits of write data. The request is held with stable fields until the cycle after the acknowledge.

Top module: `mac_eeprom_prog`

## Requirements
- R1: Address byte k is `mac_in[47-8k -: 8]`, so byte 0 is the top byte. Word i (0..2) is stored as {byte 2i+1, byte 2i}: the even byte goes in bits 7:0 and the odd byte in bits 15:8.
- R2: Word i is written to and read from EEPROM word address 7+i, and the words are handled in the order 0, 1, 2.
- R3: Every write command (op 2'd1) directly follows an acknowledged write-enable command (op 2'd0) to the same address.
- R4: Every write is directly followed by a read command (op 2'd2) to the same address. The word returned on `mw_rdata` with the acknowledge is compared with the word that was written.
- R5: A read-back mismatch repeats the full enable/write/read attempt, with at most 3 attempts per word. A matching read-back ends that word.
- R6: When all 3 attempts for word i fail, `fail_mask[i]` is set and the sequence goes on to the next word without stopping.
- R7: If a command gets no acknowledge within TIMEOUT_CYC (default 64) cycles, the attempt counts as failed. The request then drops for one cycle before the next command.
- R8: In the cycle after an accepted start, `mac_out` holds the captured address and `mac_load` is high for exactly that one cycle, before any command is issued.
- R9: `done` is a one-cycle pulse that ends the operation. `fail_mask` is valid from that cycle and holds until the next accepted start, which clears it. `busy` is high from the cycle after start through the done cycle.
- R10: If `prog_en` is low when start is accepted, the address is still loaded (R8), no command is issued, and `done` follows with `fail_mask` equal to 0.
- R11: A start pulse while `busy` is high is ignored: the captured address, the EEPROM contents and the done count are unchanged.
- R12: After reset, `busy`, `done`, `mac_load`, `mw_req`, `fail_mask` and `mac_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin an operation |
| prog_en | input | 1 | Permit EEPROM programming (sampled with start) |
| mac_in | input | 48 | Station address to store |
| mac_out | output | 48 | Captured address for the live filter |
| mac_load | output | 1 | One-cycle strobe for mac_out |
| mw_req | output | 1 | Command request to the EEPROM master |
| mw_op | output | 2 | 0 write-enable, 1 write, 2 read |
| mw_addr | output | 6 | EEPROM word address |
| mw_wdata | output | 16 | Word to write |
| mw_ack | input | 1 | One-cycle completion from the master |
| mw_rdata | input | 16 | Read data, valid with mw_ack |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| fail_mask | output | 3 | Bit i set when word i failed all attempts |

## Verification
A wrong word index or a wrong attempt count shows up at the master port within one command: a wrong address, a write with no enable before it, or a fourth attempt. It also shows up in the write and enable counts that the EEPROM model keeps. Corrupted read-backs and withheld acknowledges are injected per address, so a wrong retry decision gives a wrong `fail_mask` at the done pulse, one to a few hundred cycles after start. A capture or pulse fault shows up on `mac_out` and `mac_load` in the cycle after start.

// File: rtl/mac_prog_pkg.sv
package mac_prog_pkg;

    // operation codes on the master command port
    localparam logic [1:0] OP_EWEN  = 2'd0;
    localparam logic [1:0] OP_WRITE = 2'd1;
    localparam logic [1:0] OP_READ  = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_EWEN,
        S_WRITE,
        S_READ,
        S_RETRY,
        S_DONE
    } seq_state_e;

endpackage

// File: rtl/mac_word_pick.sv
// Splits the address into storage words, lower-numbered byte in low lane.
module mac_word_pick #(
    parameter int MAC_W  = 48,
    parameter int WORD_W = 16,
    localparam int NWORDS = MAC_W / WORD_W,
    localparam int BPW    = WORD_W / 8
) (
    input  logic [MAC_W-1:0]               mac,
    output logic [NWORDS-1:0][WORD_W-1:0]  words
);

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        for (genvar b = 0; b < BPW; b++) begin : g_byte
            localparam int K = w * BPW + b;
            assign words[w][8*b +: 8] = mac[MAC_W-1-8*K -: 8];
        end
    end

endmodule

// File: rtl/mw_cmd_timer.sv
// Counts cycles a command waits for its acknowledge.
module mw_cmd_timer #(
    parameter int LIMIT = 64,
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ack,
    output logic expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!active || ack) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = active && !ack && (cnt_q == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/mac_eeprom_prog.sv
module mac_eeprom_prog
    import mac_prog_pkg::*;
#(
    parameter int MAC_W       = 48,
    parameter int WORD_W      = 16,
    parameter int ADDR_W      = 6,
    parameter int BASE_ADDR   = 7,
    parameter int MAX_TRIES   = 3,
    parameter int TIMEOUT_CYC = 64,
    localparam int NWORDS = MAC_W / WORD_W,
    localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int TRY_W  = $clog2(MAX_TRIES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 prog_en,
    input  logic [MAC_W-1:0]     mac_in,
    output logic [MAC_W-1:0]     mac_out,
    output logic                 mac_load,
    output logic                 mw_req,
    output logic [1:0]           mw_op,
    output logic [ADDR_W-1:0]    mw_addr,
    output logic [WORD_W-1:0]    mw_wdata,
    input  logic                 mw_ack,
    input  logic [WORD_W-1:0]    mw_rdata,
    output logic                 busy,
    output logic                 done,
    output logic [NWORDS-1:0]    fail_mask
);

    localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(BASE_ADDR);
    localparam logic [WIDX_W-1:0] LAST_W   = WIDX_W'(NWORDS - 1);
    localparam logic [TRY_W-1:0]  LAST_TRY = TRY_W'(MAX_TRIES - 1);

    typedef struct packed {
        seq_state_e         st;
        logic               en;
        logic [WIDX_W-1:0]  word;
        logic [TRY_W-1:0]   tries;
        logic [NWORDS-1:0]  fmask;
        logic [MAC_W-1:0]   mac;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [NWORDS-1:0][WORD_W-1:0] words;
    logic [WORD_W-1:0]             cur_word;
    logic                          cmd_active;
    logic                          tmo;
    logic                          advance;

    mac_word_pick #(
        .MAC_W  (MAC_W),
        .WORD_W (WORD_W)
    ) u_pick (
        .mac   (r_q.mac),
        .words (words)
    );

    assign cur_word   = words[r_q.word];
    assign cmd_active = (r_q.st == S_EWEN) || (r_q.st == S_WRITE) || (r_q.st == S_READ);

    mw_cmd_timer #(
        .LIMIT (TIMEOUT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (cmd_active),
        .ack     (mw_ack),
        .expired (tmo)
    );

    always_comb begin
        r_d     = r_q;
        advance = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.mac   = mac_in;
                    r_d.en    = prog_en;
                    r_d.fmask = '0;
                    r_d.word  = '0;
                    r_d.tries = '0;
                    r_d.st    = S_LOAD;
                end
            end
            S_LOAD: begin
                r_d.st = r_q.en ? S_EWEN : S_DONE;
            end
            S_EWEN: begin
                if (mw_ack) begin
                    r_d.st = S_WRITE;
                end else if (tmo) begin
                    r_d.st = S_RETRY;
                end
            end
            S_WRITE: begin
                if (mw_ack) begin
                    r_d.st = S_READ;
                end else if (tmo) begin
                    r_d.st = S_RETRY;
                end
            end
            S_READ: begin
                if (mw_ack) begin
                    if (mw_rdata == cur_word) begin
                        advance = 1'b1;
                    end else begin
                        r_d.st = S_RETRY;
                    end
                end else if (tmo) begin
                    r_d.st = S_RETRY;
                end
            end
            S_RETRY: begin
                if (r_q.tries == LAST_TRY) begin
                    r_d.fmask[r_q.word] = 1'b1;
                    advance = 1'b1;
                end else begin
                    r_d.tries = r_q.tries + 1'b1;
                    r_d.st    = S_EWEN;
                end
            end
            S_DONE: begin
                r_d.st = S_IDLE;
            end
            default: begin
                r_d.st = S_IDLE;
            end
        endcase

        if (advance) begin
            r_d.tries = '0;
            if (r_q.word == LAST_W) begin
                r_d.st = S_DONE;
            end else begin
                r_d.word = r_q.word + 1'b1;
                r_d.st   = S_EWEN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= S_IDLE;
            r_q.en    <= 1'b0;
            r_q.word  <= '0;
            r_q.tries <= '0;
            r_q.fmask <= '0;
            r_q.mac   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.st)
            S_WRITE: mw_op = OP_WRITE;
            S_READ:  mw_op = OP_READ;
            default: mw_op = OP_EWEN;
        endcase
    end

    assign mw_req    = cmd_active;
    assign mw_addr   = BASE_A + ADDR_W'(r_q.word);
    assign mw_wdata  = cur_word;
    assign mac_out   = r_q.mac;
    assign mac_load  = (r_q.st == S_LOAD);
    assign busy      = (r_q.st != S_IDLE);
    assign done      = (r_q.st == S_DONE);
    assign fail_mask = r_q.fmask;

endmodule

// File: rtl/mac_eeprom_prog_chk.sv
module mac_eeprom_prog_chk
    import mac_prog_pkg::*;
#(
    parameter int MAC_W     = 48,
    parameter int WORD_W    = 16,
    parameter int ADDR_W    = 6,
    parameter int BASE_ADDR = 7,
    parameter int NWORDS    = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [MAC_W-1:0]   mac_out,
    input logic               mac_load,
    input logic               mw_req,
    input logic [1:0]         mw_op,
    input logic [ADDR_W-1:0]  mw_addr,
    input logic [WORD_W-1:0]  mw_wdata,
    input logic               mw_ack,
    input logic               busy,
    input logic               done,
    input logic [NWORDS-1:0]  fail_mask
);

    localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE_ADDR);
    localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE_ADDR + NWORDS);

    AST_FIRST_WORD_PACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_req && mw_op == OP_WRITE && mw_addr == LO[ADDR_W-1:0])
        |-> mw_wdata[15:0] == {mac_out[MAC_W-9 -: 8], mac_out[MAC_W-1 -: 8]}); // R1

    AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mw_req |-> ({1'b0, mw_addr} >= LO && {1'b0, mw_addr} < HI)); // R2

    AST_WRITE_AFTER_EWEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_req && mw_op == OP_WRITE && !($past(mw_req) && $past(mw_op) == OP_WRITE))
        |-> ($past(mw_req) && $past(mw_op) == OP_EWEN && $past(mw_ack) && $stable(mw_addr))); // R3

    AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_req && mw_op == OP_READ && !($past(mw_req) && $past(mw_op) == OP_READ))
        |-> ($past(mw_req) && $past(mw_op) == OP_WRITE && $past(mw_ack) && $stable(mw_addr))); // R4

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_req && $past(mw_req) && !$past(mw_ack))
        |-> ($stable(mw_op) && $stable(mw_addr) && $stable(mw_wdata))); // R7

    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mac_load |=> (!mac_load && busy)); // R8

    AST_LOAD_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        mac_load |-> !mw_req); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R9

    AST_MASK_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(fail_mask)); // R9

    AST_MAC_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mac_out)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mw_req && !done && !mac_load)); // R12

endmodule

bind mac_eeprom_prog mac_eeprom_prog_chk #(
    .MAC_W     (MAC_W),
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .NWORDS    (NWORDS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mac_out   (mac_out),
    .mac_load  (mac_load),
    .mw_req    (mw_req),
    .mw_op     (mw_op),
    .mw_addr   (mw_addr),
    .mw_wdata  (mw_wdata),
    .mw_ack    (mw_ack),
    .busy      (busy),
    .done      (done),
    .fail_mask (fail_mask)
);

// File: tb/tb_mac_eeprom_prog.sv
module tb_mac_eeprom_prog;
    import mac_prog_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        prog_en = 1'b0;
    logic [47:0] mac_in = '0;
    logic [47:0] mac_out;
    logic        mac_load;
    logic        mw_req;
    logic [1:0]  mw_op;
    logic [5:0]  mw_addr;
    logic [15:0] mw_wdata;
    logic        mw_ack = 1'b0;
    logic [15:0] mw_rdata = '0;
    logic        busy;
    logic        done;
    logic [2:0]  fail_mask;

    always #10 clk = ~clk;

    mac_eeprom_prog dut (
        .clk(clk), .rst_n(rst_n), .start(start), .prog_en(prog_en),
        .mac_in(mac_in), .mac_out(mac_out), .mac_load(mac_load),
        .mw_req(mw_req), .mw_op(mw_op), .mw_addr(mw_addr), .mw_wdata(mw_wdata),
        .mw_ack(mw_ack), .mw_rdata(mw_rdata), .busy(busy), .done(done),
        .fail_mask(fail_mask)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // EEPROM and master model state
    logic [15:0] mem [64];
    int corrupt_left [64];
    int drop_addr = -1;
    int drop_left = 0;
    int ewen_cnt, wr_cnt, rd_cnt, order_err, done_cnt;
    logic [2:0] mask_at_done;
    logic load_seen, wen;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [47:0] m, input int i);
        logic [7:0] even_b, odd_b;
        even_b = m[47-16*i -: 8];
        odd_b  = m[39-16*i -: 8];
        return {odd_b, even_b};
    endfunction

    // master model: two-cycle latency, per-address corruption and dropped acks
    initial begin
        wen = 1'b0;
        forever begin
            @(negedge clk);
            mw_ack = 1'b0;
            if (mw_req) begin
                automatic logic [1:0] op = mw_op;
                automatic int a = int'(mw_addr);
                automatic logic [15:0] d = mw_wdata;
                if (!load_seen) order_err++;
                if (a == drop_addr && drop_left > 0) begin
                    drop_left--;
                    while (mw_req) @(negedge clk);
                end else begin
                    repeat (2) @(negedge clk);
                    case (op)
                        OP_EWEN: begin ewen_cnt++; wen = 1'b1; end
                        OP_WRITE: begin
                            wr_cnt++;
                            if (!wen) order_err++;
                            mem[a] = d;
                            wen = 1'b0;
                        end
                        default: begin
                            rd_cnt++;
                            if (corrupt_left[a] > 0) begin
                                mw_rdata = mem[a] ^ 16'h0100;
                                corrupt_left[a]--;
                            end else begin
                                mw_rdata = mem[a];
                            end
                        end
                    endcase
                    mw_ack = 1'b1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (mac_load) load_seen = 1'b1;
        if (done) begin
            done_cnt++;
            mask_at_done = fail_mask;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic clear_model();
        for (int i = 0; i < 64; i++) begin
            mem[i] = 16'hFFFF;
            corrupt_left[i] = 0;
        end
        drop_addr = -1;
        drop_left = 0;
        ewen_cnt = 0; wr_cnt = 0; rd_cnt = 0; order_err = 0; done_cnt = 0;
        load_seen = 1'b0;
    endtask

    task automatic kick(input logic [47:0] m, input logic en);
        @(negedge clk);
        mac_in = m; prog_en = en; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 load strobe", {63'd0, mac_load}, 64'd1);
        chk("R8 captured address", {16'd0, mac_out}, {16'd0, m});
        chk("R9 busy after start", {63'd0, busy}, 64'd1);
    endtask

    task automatic wait_done();
        int t = 0;
        while (done_cnt == 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
    endtask

    // stimulus table: address, corrupt read-backs for words 0..2, expected mask
    localparam int NV = 5;
    localparam logic [56:0] VEC [NV] = '{
        {48'h001122334455, 2'd0, 2'd0, 2'd0, 3'b000},
        {48'hA1B2C3D4E5F6, 2'd1, 2'd0, 2'd2, 3'b000},
        {48'hFFFFFFFFFFFF, 2'd3, 2'd0, 2'd0, 3'b001},
        {48'h800000000001, 2'd3, 2'd3, 2'd3, 3'b111},
        {48'h0123456789AB, 2'd0, 2'd3, 2'd0, 3'b010}
    };

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 busy", {63'd0, busy}, 64'd0);
        chk("R12 req", {63'd0, mw_req}, 64'd0);
        chk("R12 done/load", {62'd0, done, mac_load}, 64'd0);
        chk("R12 mask/mac", {13'd0, fail_mask, mac_out}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            automatic logic [47:0] m = VEC[v][56:9];
            automatic int c [3];
            automatic int exp_wr = 0;
            automatic logic [2:0] emask;
            c[0] = int'(VEC[v][8:7]);
            c[1] = int'(VEC[v][6:5]);
            c[2] = int'(VEC[v][4:3]);
            emask = VEC[v][2:0];
            clear_model();
            for (int i = 0; i < 3; i++) begin
                corrupt_left[7+i] = c[i];
                exp_wr += (c[i] >= 3) ? 3 : c[i] + 1;
            end
            kick(m, 1'b1);
            wait_done();
            chk("R9 done pulse seen", 64'(done_cnt), 64'd1);
            chk("R6 fail mask", {61'd0, mask_at_done}, {61'd0, emask});
            chk("R5 write attempts", 64'(wr_cnt), 64'(exp_wr));
            chk("R4 read per write", 64'(rd_cnt), 64'(exp_wr));
            chk("R3 enable before write", 64'(ewen_cnt), 64'(exp_wr));
            chk("R3 R8 command order", 64'(order_err), 64'd0);
            for (int i = 0; i < 3; i++) begin
                chk("R1 R2 stored word", {48'd0, mem[7+i]}, {48'd0, exp_word(m, i)});
            end
            chk("R2 neighbour untouched", {48'd0, mem[6]} | {48'd0, mem[10]} << 16,
                {48'd0, 16'hFFFF} | {48'd0, 16'hFFFF} << 16);
            repeat (5) @(negedge clk);
            chk("R9 idle after done", {63'd0, busy}, 64'd0);
            chk("R9 mask held", {61'd0, fail_mask}, {61'd0, emask});
        end

        // R10: programming disabled
        clear_model();
        kick(48'hDEADBEEF0042, 1'b0);
        wait_done();
        chk("R10 done", 64'(done_cnt), 64'd1);
        chk("R10 no commands", 64'(ewen_cnt + wr_cnt + rd_cnt), 64'd0);
        chk("R10 mask zero", {61'd0, mask_at_done}, 64'd0);
        chk("R10 mac loaded", {16'd0, mac_out}, {16'd0, 48'hDEADBEEF0042});

        // R11: start while busy is ignored
        clear_model();
        kick(48'h112233445566, 1'b1);
        repeat (6) @(negedge clk);
        mac_in = 48'h998877665544; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (200) @(negedge clk);
        chk("R11 single done", 64'(done_cnt), 64'd1);
        chk("R11 mac kept", {16'd0, mac_out}, {16'd0, 48'h112233445566});
        chk("R11 word0 kept", {48'd0, mem[7]}, {48'd0, exp_word(48'h112233445566, 0)});
        chk("R11 write count", 64'(wr_cnt), 64'd3);

        // R7: one withheld ack then recovery
        clear_model();
        drop_addr = 8; drop_left = 1;
        kick(48'h0A0B0C0D0E0F, 1'b1);
        wait_done();
        chk("R7 single timeout recovers", {61'd0, mask_at_done}, 64'd0);
        chk("R7 enable count", 64'(ewen_cnt), 64'd3);
        chk("R7 stored word1", {48'd0, mem[8]}, {48'd0, exp_word(48'h0A0B0C0D0E0F, 1)});

        // R7 R6: three withheld acks fail the word, sequence continues
        clear_model();
        drop_addr = 8; drop_left = 3;
        kick(48'h102030405060, 1'b1);
        wait_done();
        chk("R7 timeout failure mask", {61'd0, mask_at_done}, 64'd2);
        chk("R6 word2 still written", {48'd0, mem[9]}, {48'd0, exp_word(48'h102030405060, 2)});
        chk("R6 word1 untouched", {48'd0, mem[8]}, {48'd0, 16'hFFFF});

        // R9: next start clears the mask
        clear_model();
        kick(48'h000000000001, 1'b1);
        chk("R9 mask cleared on start", {61'd0, fail_mask}, 64'd0);
        wait_done();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule